// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dialing Sequencer

This block turns a stream of dialing commands into loop-disconnect pulse trains on a dial-pulse output, and raises a mute output for the whole of every dialing action. Each digit is framed by a pre-digit make interval and a trailing inter-digit pause. The pulse rate is 10 or 20 pulses per second, and the make share of each pulse period is 40 % or one third. Other commands insert a long pause, a timed flash break followed by a flash recovery pause, or a one-way switch from pulse to tone signalling. After that switch, digits leave on a tone strobe path for the rest of the call.

The block watches the hook state. Going on-hook aborts any action in progress and clears tone mode. Going off-hook while lock is requested holds the line broken for 300 ms before any command is accepted. Every interval is counted in ticks of 1/TICKS_PER_MS ms, and each tick is CLKS_PER_TICK clocks of one crystal-derived clock.

Top module: `pulse_dialer`

## Requirements
- R1: While hook_on_i is 1, and after reset, dp_o=1, mute_o=0, tone_mode_o=0 and cmd_ready_o=0. Raising hook_on_i aborts any action at the next edge. It also blocks command acceptance in the same cycle.
- R2: On the first edge with hook_on_i=0 after on-hook, if lock_i=1, dp_o is 0 and mute_o is 1 for 300 ms and then the block goes idle. If lock_i=0, cmd_ready_o rises one cycle later.
- R3: Command codes 1 to 9 give that many breaks on dp_o (dp_o=0), and code 0 gives ten breaks.
- R4: The pulse period is 100 ms when rate_20_i=0 and 50 ms when rate_20_i=1. The make share of the period is 40 % when ratio_third_i=0 and one third when ratio_third_i=1. Each digit starts with one make interval (pre-digit pause), and breaks alternate with makes.
- R5: The last break of a digit is followed by 800 ms (10 pps) or 500 ms (20 pps) of make. mute_o stays 1 from the pre-digit interval to the end of this pause.
- R6: Code 12 gives a 3.6 s pause with dp_o=1 and mute_o=1, in either mode.
- R7: Codes 16 to 19 select flash breaks of 600, 300, 73 and 100 ms (by cmd_i[1:0]). Each break is followed by a 1.0 s make with mute_o=1, in pulse and tone mode alike.
- R8: Code 13 in pulse mode sets tone_mode_o at the acceptance edge and is followed by a 3.6 s pause. With STAR_ON_SWITCH=1 it instead sends a star tone (code 10). In tone mode, code 13 sends a star tone.
- R9: In tone mode, codes 0 to 11 raise tone_stb_o for exactly one cycle, with the code on tone_code_o and mute_o=1, and produce no break on dp_o.
- R10: In pulse mode, codes 10 and 11, and codes 14, 15 and 20 to 31 in either mode, are consumed without effect. Outputs stay idle and cmd_ready_o stays 1.
- R11: tone_mode_o, once set, holds through pauses, flashes and tone digits until hook_on_i is 1.
- R12: Every interval of N ms lasts exactly N*TICKS_PER_MS*CLKS_PER_TICK clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hook_on_i | input | 1 | 1 = handset on-hook |
| lock_i | input | 1 | Request 300 ms broken-line delay at off-hook |
| rate_20_i | input | 1 | 1 = 20 pps, 0 = 10 pps |
| ratio_third_i | input | 1 | 1 = one-third make share, 0 = 40 % make share |
| cmd_valid_i | input | 1 | Command offered |
| cmd_i | input | 5 | Command code (0-9 digit, 10 star, 11 hash, 12 pause, 13 tone switch, 16-19 flash) |
| cmd_ready_o | output | 1 | Command accepted this cycle when valid |
| dp_o | output | 1 | Loop state, 0 = break |
| mute_o | output | 1 | 1 while a dialing action runs |
| tone_mode_o | output | 1 | 1 after the pulse-to-tone switch |
| tone_stb_o | output | 1 | One-cycle tone request |
| tone_code_o | output | 4 | Code of the tone request |

## Verification
Two events can fall in the same cycle: the hook going on and a command being offered. The bench provokes this by raising hook_on_i and cmd_valid_i on the same falling edge while the block is idle in tone mode. It then expects cmd_ready_o low in that cycle, no tone strobe afterwards, and tone mode cleared. A second collision raises the hook in the middle of a digit's pulse train; the bench expects dp_o and mute_o to return to idle at the very next edge. A behavioural segment model compares every output on every clock through both collisions.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [3:0] {
    S_ONHOOK, S_LOCK, S_IDLE, S_PRE, S_BRK, S_MAKE, S_IDP,
    S_PAUSE, S_FBRK, S_FPAUSE, S_TONE
  } pd_state_e;

  localparam logic [4:0] CODE_LAST_DIGIT = 5'd9;
  localparam logic [4:0] CODE_LAST_TONE  = 5'd11;
  localparam logic [4:0] CODE_PAUSE      = 5'd12;
  localparam logic [4:0] CODE_TONE_SW    = 5'd13;
  localparam logic [3:0] TONE_STAR       = 4'd10;

  function automatic logic is_flash(input logic [4:0] c);
    return c[4:2] == 3'b100;
  endfunction
endpackage

// File: rtl/pd_tick_gen.sv
module pd_tick_gen #(
  parameter int CLKS_PER_TICK = 16667
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PRE_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(CLKS_PER_TICK - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pre_q <= '0;
    else if (clr_i)          pre_q <= '0;
    else if (pre_q == LAST)  pre_q <= '0;
    else                     pre_q <= pre_q + 1'b1;
  end

  assign tick_o = (pre_q == LAST);

  if (CLKS_PER_TICK > 1) begin : g_tick_chk
    assert_tick_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/pd_timer.sv
module pd_timer #(
  parameter int TMR_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // last cycle of the loaded interval
  assign expire_o = tick_i && (cnt_q == TMR_W'(1));

  assert_expire_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
endmodule

// File: rtl/pd_timing.sv
module pd_timing #(
  parameter int TICKS_PER_MS = 3,
  parameter int TMR_W        = 14
) (
  input  logic             rate_20_i,
  input  logic             ratio_third_i,
  input  logic [1:0]       flash_sel_i,
  output logic [TMR_W-1:0] make_o,
  output logic [TMR_W-1:0] brk_o,
  output logic [TMR_W-1:0] idp_o,
  output logic [TMR_W-1:0] flash_o,
  output logic [TMR_W-1:0] fpause_o,
  output logic [TMR_W-1:0] pause_o,
  output logic [TMR_W-1:0] lock_o
);
  localparam int PER10   = 100 * TICKS_PER_MS;
  localparam int PER20   = 50 * TICKS_PER_MS;
  localparam int MK10_40 = PER10 * 2 / 5;
  localparam int MK10_33 = PER10 / 3;
  localparam int MK20_40 = PER20 * 2 / 5;
  localparam int MK20_33 = PER20 / 3;
  localparam int FLASH_MS [4] = '{600, 300, 73, 100};

  always_comb begin
    case ({rate_20_i, ratio_third_i})
      2'b00:   begin make_o = TMR_W'(MK10_40); brk_o = TMR_W'(PER10 - MK10_40); end
      2'b01:   begin make_o = TMR_W'(MK10_33); brk_o = TMR_W'(PER10 - MK10_33); end
      2'b10:   begin make_o = TMR_W'(MK20_40); brk_o = TMR_W'(PER20 - MK20_40); end
      default: begin make_o = TMR_W'(MK20_33); brk_o = TMR_W'(PER20 - MK20_33); end
    endcase
  end

  assign idp_o    = rate_20_i ? TMR_W'(500 * TICKS_PER_MS) : TMR_W'(800 * TICKS_PER_MS);
  assign flash_o  = TMR_W'(FLASH_MS[flash_sel_i] * TICKS_PER_MS);
  assign fpause_o = TMR_W'(1000 * TICKS_PER_MS);
  assign pause_o  = TMR_W'(3600 * TICKS_PER_MS);
  assign lock_o   = TMR_W'(300 * TICKS_PER_MS);
endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer #(
  parameter int CLKS_PER_TICK  = 16667,
  parameter int TICKS_PER_MS   = 3,
  parameter bit STAR_ON_SWITCH = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hook_on_i,
  input  logic       lock_i,
  input  logic       rate_20_i,
  input  logic       ratio_third_i,
  input  logic       cmd_valid_i,
  input  logic [4:0] cmd_i,
  output logic       cmd_ready_o,
  output logic       dp_o,
  output logic       mute_o,
  output logic       tone_mode_o,
  output logic       tone_stb_o,
  output logic [3:0] tone_code_o
);
  import pd_pkg::*;

  localparam int LONGEST_MS = 3600;
  localparam int TMR_W      = $clog2(LONGEST_MS * TICKS_PER_MS + 1);

  pd_state_e        state_q, state_d;
  logic [3:0]       left_q, left_d;
  logic [3:0]       code_q, code_d;
  logic             tone_q, tone_d;
  logic             load;
  logic [TMR_W-1:0] load_val;
  logic             tick, expire;
  logic [TMR_W-1:0] make_t, brk_t, idp_t, flash_t, fpause_t, pause_t, lock_t;

  pd_timing #(.TICKS_PER_MS(TICKS_PER_MS), .TMR_W(TMR_W)) i_timing (
    .rate_20_i     (rate_20_i),
    .ratio_third_i (ratio_third_i),
    .flash_sel_i   (cmd_i[1:0]),
    .make_o        (make_t),
    .brk_o         (brk_t),
    .idp_o         (idp_t),
    .flash_o       (flash_t),
    .fpause_o      (fpause_t),
    .pause_o       (pause_t),
    .lock_o        (lock_t)
  );

  pd_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .tick_o (tick)
  );

  pd_timer #(.TMR_W(TMR_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .tick_i     (tick),
    .expire_o   (expire)
  );

  assign cmd_ready_o = (state_q == S_IDLE) && !hook_on_i;

  always_comb begin
    state_d  = state_q;
    left_d   = left_q;
    code_d   = code_q;
    tone_d   = tone_q;
    load     = 1'b0;
    load_val = '0;
    if (hook_on_i) begin
      state_d = S_ONHOOK;
      tone_d  = 1'b0;
    end else begin
      case (state_q)
        S_ONHOOK: begin
          if (lock_i) begin
            state_d = S_LOCK; load = 1'b1; load_val = lock_t;
          end else begin
            state_d = S_IDLE;
          end
        end
        S_LOCK: if (expire) state_d = S_IDLE;
        S_IDLE: begin
          if (cmd_valid_i) begin
            if (tone_q && cmd_i <= CODE_LAST_TONE) begin
              state_d = S_TONE; code_d = cmd_i[3:0];
            end else if (cmd_i <= CODE_LAST_DIGIT) begin
              state_d  = S_PRE;
              left_d   = (cmd_i[3:0] == 4'd0) ? 4'd10 : cmd_i[3:0];
              load     = 1'b1;
              load_val = make_t;
            end else if (cmd_i == CODE_PAUSE) begin
              state_d = S_PAUSE; load = 1'b1; load_val = pause_t;
            end else if (cmd_i == CODE_TONE_SW) begin
              if (tone_q || STAR_ON_SWITCH) begin
                state_d = S_TONE; code_d = TONE_STAR;
              end else begin
                state_d = S_PAUSE; load = 1'b1; load_val = pause_t;
              end
              tone_d = 1'b1;
            end else if (is_flash(cmd_i)) begin
              state_d = S_FBRK; load = 1'b1; load_val = flash_t;
            end
          end
        end
        S_PRE: if (expire) begin
          state_d = S_BRK; load = 1'b1; load_val = brk_t;
        end
        S_BRK: if (expire) begin
          load = 1'b1;
          if (left_q == 4'd1) begin
            state_d = S_IDP; load_val = idp_t;
          end else begin
            state_d = S_MAKE; load_val = make_t;
          end
          left_d = left_q - 4'd1;
        end
        S_MAKE: if (expire) begin
          state_d = S_BRK; load = 1'b1; load_val = brk_t;
        end
        S_FBRK: if (expire) begin
          state_d = S_FPAUSE; load = 1'b1; load_val = fpause_t;
        end
        S_IDP, S_PAUSE, S_FPAUSE: if (expire) state_d = S_IDLE;
        S_TONE:  state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_ONHOOK;
      left_q  <= '0;
      code_q  <= '0;
      tone_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      code_q  <= code_d;
      tone_q  <= tone_d;
    end
  end

  assign dp_o        = !(state_q inside {S_LOCK, S_BRK, S_FBRK});
  assign mute_o      = !(state_q inside {S_ONHOOK, S_IDLE});
  assign tone_mode_o = tone_q;
  assign tone_stb_o  = (state_q == S_TONE);
  assign tone_code_o = code_q;

  assert_onhook_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hook_on_i |=> (dp_o && !mute_o && !tone_mode_o));

  assert_lock_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LOCK && $past(state_q) == S_ONHOOK) |-> $past(lock_i));

  assert_break_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BRK) |-> (left_q != 4'd0 && left_q <= 4'd10));

  assert_break_muted_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dp_o |-> mute_o);

  assert_strobe_in_tone_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_stb_o |-> tone_mode_o);

  assert_tone_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tone_mode_o && !hook_on_i) |=> tone_mode_o);
endmodule

// File: tb/test_pulse_dialer.sv
`timescale 1ns/1ps
module test_pulse_dialer;
  localparam int DIV = 2;
  localparam int TPM = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hook_on = 1'b1, lock = 1'b0, rate20 = 1'b0, ratio3 = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [4:0] cmd = '0;
  logic       cmd_ready, dp, mute, tone_mode, tone_stb;
  logic [3:0] tone_code;

  int    checks = 0, errs = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #10 clk = ~clk;

  pulse_dialer #(.CLKS_PER_TICK(DIV), .TICKS_PER_MS(TPM), .STAR_ON_SWITCH(1'b0)) i_pulse_dialer (
    .clk_i(clk), .rst_ni(rst_n), .hook_on_i(hook_on), .lock_i(lock),
    .rate_20_i(rate20), .ratio_third_i(ratio3), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .cmd_ready_o(cmd_ready), .dp_o(dp), .mute_o(mute), .tone_mode_o(tone_mode),
    .tone_stb_o(tone_stb), .tone_code_o(tone_code));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model: queue of output segments, lengths in clock cycles
  typedef struct { bit dp; bit mu; bit st; int code; int len; } seg_t;
  seg_t q[$];
  bit   m_tone = 0, m_onhook = 1, was_idle;

  task automatic push(input bit d, input bit m, input bit s, input int c, input int len);
    seg_t g;
    g.dp = d; g.mu = m; g.st = s; g.code = c; g.len = len;
    q.push_back(g);
  endtask

  task automatic model_cmd(input int c);
    int per, mk, n;
    if (m_tone && c <= 11) push(1, 1, 1, c, 1);
    else if (c <= 9) begin
      per = (rate20 ? 50 : 100) * TPM;
      mk  = ratio3 ? per / 3 : per * 2 / 5;
      n   = (c == 0) ? 10 : c;
      push(1, 1, 0, 0, mk * DIV);
      for (int k = 1; k <= n; k++) begin
        push(0, 1, 0, 0, (per - mk) * DIV);
        if (k < n) push(1, 1, 0, 0, mk * DIV);
        else push(1, 1, 0, 0, (rate20 ? 500 : 800) * TPM * DIV);
      end
    end else if (c == 12) push(1, 1, 0, 0, 3600 * TPM * DIV);
    else if (c == 13) begin
      if (m_tone) push(1, 1, 1, 10, 1);
      else begin m_tone = 1; push(1, 1, 0, 0, 3600 * TPM * DIV); end
    end else if (c >= 16 && c <= 19) begin
      case (c)
        16: n = 600;
        17: n = 300;
        18: n = 73;
        default: n = 100;
      endcase
      push(0, 1, 0, 0, n * TPM * DIV);
      push(1, 1, 0, 0, 1000 * TPM * DIV);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_tone = 0; m_onhook = 1;
    end else begin
      was_idle = (q.size() == 0) && !m_onhook;
      if (hook_on) begin
        q.delete(); m_tone = 0; m_onhook = 1;
      end else if (m_onhook) begin
        m_onhook = 0;
        if (lock) push(0, 1, 0, 0, 300 * TPM * DIV);
      end else begin
        if (q.size() > 0) begin
          q[0].len = q[0].len - 1;
          if (q[0].len == 0) void'(q.pop_front());
        end
        if (was_idle && cmd_valid) model_cmd(int'(cmd));
      end
    end
  end

  // compare every cycle, 5 ns after the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      if (q.size() > 0) begin
        chk(cur_req, "dp", dp, q[0].dp);
        chk(cur_req, "mute", mute, q[0].mu);
        chk(cur_req, "tone_stb", tone_stb, q[0].st);
        if (q[0].st) chk(cur_req, "tone_code", tone_code, q[0].code);
      end else begin
        chk(cur_req, "dp", dp, 1);
        chk(cur_req, "mute", mute, 0);
        chk(cur_req, "tone_stb", tone_stb, 0);
      end
      chk(cur_req, "tone_mode", tone_mode, m_tone);
      chk(cur_req, "ready", cmd_ready, (q.size() == 0 && !m_onhook && !hook_on) ? 1 : 0);
    end
  end

  task automatic send(input int c);
    @(negedge clk); cmd_valid = 1'b1; cmd = 5'(c);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic send_wait(input int c);
    send(c);
    wait_idle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog all requirements: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk("R1", "reset dp", dp, 1); chk("R1", "reset mute", mute, 0);
    chk("R1", "reset tone", tone_mode, 0); chk("R1", "reset ready", cmd_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "onhook ready", cmd_ready, 0);

    // R2: lock delay
    cur_req = "R2"; lock = 1'b1; hook_on = 1'b0;
    @(negedge clk);
    cnt = 0;
    while (!dp) begin cnt++; @(negedge clk); end
    chk("R2", "lock break cycles", cnt, 300 * TPM * DIV);
    wait_idle();

    cur_req = "R3"; rate20 = 1'b1; ratio3 = 1'b0; send_wait(2);
    cur_req = "R4/R5"; rate20 = 1'b0; ratio3 = 1'b1; send_wait(0);

    cur_req = "R12"; rate20 = 1'b1; ratio3 = 1'b1; send(1);
    while (dp) @(negedge clk);
    cnt = 0;
    while (!dp) begin cnt++; @(negedge clk); end
    chk("R12", "break cycles 20pps third", cnt, 50 * TPM / 3 * 2 * DIV);
    wait_idle();

    cur_req = "R10"; rate20 = 1'b0; ratio3 = 1'b0;
    send(10); chk("R10", "star pulse ready", cmd_ready, 1); chk("R10", "star dp", dp, 1);
    send(14); chk("R10", "code14 mute", mute, 0);
    send(25); chk("R10", "code25 ready", cmd_ready, 1);
    send(11); chk("R10", "hash tone", tone_mode, 0);

    cur_req = "R6"; send_wait(12);
    cur_req = "R7"; send_wait(18);

    // on-hook in mid pulse train
    cur_req = "R1"; rate20 = 1'b1; send(3);
    repeat (300) @(negedge clk);
    hook_on = 1'b1;
    @(negedge clk);
    chk("R1", "abort dp", dp, 1); chk("R1", "abort mute", mute, 0);
    cur_req = "R2"; lock = 1'b0; hook_on = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", "no lock ready", cmd_ready, 1);

    cur_req = "R8"; send(13);
    chk("R8", "tone set", tone_mode, 1);
    wait_idle();

    cur_req = "R9"; send(7);
    chk("R9", "tone strobe", tone_stb, 1); chk("R9", "tone code", tone_code, 7);
    chk("R9", "tone dp", dp, 1);
    wait_idle();
    send_wait(0); send_wait(11);
    cur_req = "R8"; send(13);
    chk("R8", "star strobe", tone_stb, 1); chk("R8", "star code", tone_code, 10);
    wait_idle();

    cur_req = "R11"; send_wait(19);
    chk("R11", "tone after flash", tone_mode, 1);
    cur_req = "R7"; send_wait(16);

    // on-hook and command in the same cycle
    cur_req = "R1";
    @(negedge clk); hook_on = 1'b1; cmd_valid = 1'b1; cmd = 5'd5;
    #1 chk("R1", "ready on hook", cmd_ready, 0);
    @(negedge clk);
    chk("R1", "no strobe", tone_stb, 0); chk("R11", "tone cleared", tone_mode, 0);
    cmd_valid = 1'b0;

    cur_req = "R2"; lock = 1'b1; hook_on = 1'b0;
    wait_idle();
    cur_req = "R7"; send_wait(17);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule